// File: doc/BRIEF.md
# Post-Divider with Stepped Power-Down

This block turns a fast source clock into a slower output clock with an exact 50% duty cycle. The output always includes a fixed divide-by-two prescale, so for a post-divide ratio R it stays high for R source cycles and low for R source cycles. A 2-bit select chooses R, and this select uses a non-binary code. An output-enable gates the output only at period boundaries. A disabled output therefore sits low, and a high pulse that has started always runs its full length.

A power-down request, sampled on a slower reference clock, multiplies the ratio by 2^STEPS (16 by default). It does this one doubling at a time, and each step is held for PACE reference cycles. Releasing the request walks back down the same way. The current step count is reported on a status output. A toggle handshake moves the step count into the source-clock domain. Every new ratio, whether it comes from the select or from a step, takes effect only at the start of an output period.

Top module: `pd_postdiv`

## Requirements
- R1: With no power-down active, the output high time H in source cycles follows `sel_n`: code 2'b11 gives H=1, 2'b00 gives H=2, 2'b01 gives H=4 and 2'b10 gives H=8.
- R2: In every output period, the low time equals the high time.
- R3: Once the step status reaches STEPS (4), H is 2^STEPS times the value given by R1 (16 for 2'b11, 128 for 2'b10).
- R4: While power-down is requested, the status `pd_step` climbs from 0 to STEPS by exactly one per change. While it shows k, H is 2^k times the R1 value.
- R5: Two successive status changes that do not start from an end value (0 or STEPS) are exactly PACE reference cycles apart.
- R6: When the request is released, the status descends by one per change to 0. At step k, H is 2^k times the R1 value, and at 0 the programmed ratio is restored.
- R7: If `oe` is deasserted during a high phase, that high phase still lasts its full H. After that the output stays low until `oe` returns, and it then resumes with the programmed H.
- R8: A ratio change takes effect only at the rising edge that starts a period. When `sel_n` changes at arbitrary times, every observed period still has equal high and low times, and those times are legal values.
- R9: While reset is asserted, the output is low and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| clk_ref | input | 1 | Reference clock that paces power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sel_n | input | 2 | Post-divide select (source-clock domain) |
| pd_req | input | 1 | Power-down request (reference-clock domain) |
| oe | input | 1 | Output enable (source-clock domain) |
| clk_out | output | 1 | Divided, gated output clock |
| pd_step | output | 3 | Current power-down step, 0 to STEPS |

## Verification
The registered output rises one source cycle after the counter wraps at the end of a low phase, and a new select value first appears in the period after that rise. The bench therefore waits at least one maximum period after each stimulus and then measures whole periods, counting falling-edge samples from a rising edge of the output. A step change reaches the divider a few source cycles after the status moves and then waits for the next period start. The step measurements are made 60 source cycles into each dwell, which lasts 256 cycles with the bench's PACE of 64. Status changes are sampled on the falling edge of the reference clock, and the spacing between them is counted in reference cycles.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Maps the post-divide select code to log2 of the ratio.
    function automatic logic [1:0] sel_to_exp(input logic [1:0] code);
        logic [1:0] e;
        case (code)
            2'b11:   e = 2'd0;
            2'b00:   e = 2'd1;
            2'b01:   e = 2'd2;
            default: e = 2'd3;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pd_pacer.sv
module pd_pacer #(
    parameter int STEPS = 4,
    parameter int PACE  = 4,
    localparam int SW   = $clog2(STEPS + 1),
    localparam int PW   = (PACE > 1) ? $clog2(PACE) : 1
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          pd_req,
    input  logic          ack_tog,
    output logic [SW-1:0] step_o,
    output logic          req_tog
);

    typedef struct packed {
        logic          pd;
        logic [SW-1:0] step;
        logic [PW-1:0] pace;
        logic          req;
        logic          ack_s1;
        logic          ack_s2;
    } pacer_t;

    pacer_t st_d, st_q;
    logic   busy;
    logic [SW-1:0] target;

    always_comb begin
        st_d        = st_q;
        st_d.pd     = pd_req;
        st_d.ack_s1 = ack_tog;
        st_d.ack_s2 = st_q.ack_s1;
        busy        = st_q.req ^ st_q.ack_s2;
        target      = st_q.pd ? SW'(STEPS) : '0;
        if (st_q.step == target) begin
            st_d.pace = '0;
        end else if (st_q.pace == PW'(PACE - 1)) begin
            if (!busy) begin
                st_d.step = (st_q.step < target) ? st_q.step + 1'b1 : st_q.step - 1'b1;
                st_d.req  = ~st_q.req;
                st_d.pace = '0;
            end
        end else begin
            st_d.pace = st_q.pace + 1'b1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o  = st_q.step;
    assign req_tog = st_q.req;

    AST_STEP_MAX: assert property (@(posedge clk_ref) disable iff (!rst_n)
        st_q.step <= SW'(STEPS)); // R4
    AST_STEP_WAITS_ACK: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(st_q.step) |-> $past(st_q.req) == $past(st_q.ack_s2)); // R5
    AST_STEP_UP_ONLY_IN_PD: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_q.step > $past(st_q.step)) |-> $past(st_q.pd)); // R4
    AST_STEP_DOWN_ONLY_OUT_PD: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_q.step < $past(st_q.step)) |-> !$past(st_q.pd)); // R6

endmodule

// File: rtl/step_rx.sv
module step_rx #(
    parameter int SW = 3
) (
    input  logic          clk_src,
    input  logic          rst_n,
    input  logic          req_tog,
    input  logic [SW-1:0] step_in,
    output logic [SW-1:0] step_o,
    output logic          ack_tog
);

    typedef struct packed {
        logic          r1;
        logic          r2;
        logic          ack;
        logic [SW-1:0] step;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d    = rx_q;
        rx_d.r1 = req_tog;
        rx_d.r2 = rx_q.r1;
        if (rx_q.r2 != rx_q.ack) begin
            rx_d.step = step_in;
            rx_d.ack  = rx_q.r2;
        end
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign step_o  = rx_q.step;
    assign ack_tog = rx_q.ack;

    AST_RX_ONE_STEP: assert property (@(posedge clk_src) disable iff (!rst_n)
        !$stable(rx_q.step) |-> ((rx_q.step == $past(rx_q.step) + 1'b1) ||
                                  (rx_q.step == $past(rx_q.step) - 1'b1))); // R4

endmodule

// File: rtl/post_div.sv
module post_div #(
    parameter int STEPS = 4,
    localparam int SW   = $clog2(STEPS + 1),
    localparam int CW   = 3 + STEPS,
    localparam int EW   = $clog2(CW + 1)
) (
    input  logic          clk_src,
    input  logic          rst_n,
    input  logic [1:0]    sel_n,
    input  logic [SW-1:0] step,
    input  logic          oe,
    output logic          clk_out
);
    import pdiv_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
        logic [EW-1:0] ex;
        logic          en;
        logic          out;
    } div_t;

    div_t          dv_d, dv_q;
    logic [CW:0]   half_w;
    logic [CW-1:0] lim;
    logic          wrap;

    always_comb begin
        half_w = {{CW{1'b0}}, 1'b1} << dv_q.ex;
        lim    = CW'(half_w - 1'b1);
        wrap   = (dv_q.cnt == lim);
        dv_d   = dv_q;
        if (!wrap) begin
            dv_d.cnt = dv_q.cnt + 1'b1;
        end else begin
            dv_d.cnt = '0;
            if (dv_q.ph) begin
                dv_d.ph = 1'b0;
            end else begin
                dv_d.ph = 1'b1;
                dv_d.ex = EW'(sel_to_exp(sel_n)) + EW'(step);
                dv_d.en = oe;
            end
        end
        dv_d.out = dv_d.ph & dv_d.en;
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign clk_out = dv_q.out;

    AST_OFF_STAYS_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
        !dv_q.en |-> !clk_out); // R7
    AST_CNT_IN_RANGE: assert property (@(posedge clk_src) disable iff (!rst_n)
        dv_q.cnt <= lim); // R2
    AST_RATIO_AT_START: assert property (@(posedge clk_src) disable iff (!rst_n)
        !$stable(dv_q.ex) |-> (dv_q.ph && !$past(dv_q.ph))); // R8
    AST_RISE_AT_START: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(clk_out) |-> (dv_q.cnt == '0 && dv_q.ph)); // R8

endmodule

// File: rtl/pd_postdiv.sv
module pd_postdiv #(
    parameter int STEPS = 4,
    parameter int PACE  = 4,
    localparam int SW   = $clog2(STEPS + 1)
) (
    input  logic          clk_src,
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic [1:0]    sel_n,
    input  logic          pd_req,
    input  logic          oe,
    output logic          clk_out,
    output logic [SW-1:0] pd_step
);

    logic          req_tog;
    logic          ack_tog;
    logic [SW-1:0] step_ref;
    logic [SW-1:0] step_src;

    pd_pacer #(.STEPS(STEPS), .PACE(PACE)) i_pacer (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .pd_req  (pd_req),
        .ack_tog (ack_tog),
        .step_o  (step_ref),
        .req_tog (req_tog)
    );

    step_rx #(.SW(SW)) i_rx (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .req_tog (req_tog),
        .step_in (step_ref),
        .step_o  (step_src),
        .ack_tog (ack_tog)
    );

    post_div #(.STEPS(STEPS)) i_div (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .step    (step_src),
        .oe      (oe),
        .clk_out (clk_out)
    );

    assign pd_step = step_ref;

endmodule

// File: tb/test_pd_postdiv.sv
module test_pd_postdiv;
    localparam int STEPS = 4;
    localparam int PACE  = 64;

    logic       clk_src = 1'b0;
    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] sel_n   = 2'b11;
    logic       pd_req  = 1'b0;
    logic       oe      = 1'b1;
    logic       clk_out;
    logic [2:0] pd_step;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5  clk_src = ~clk_src;
    always #20 clk_ref = ~clk_ref;

    pd_postdiv #(.STEPS(STEPS), .PACE(PACE)) i_pd_postdiv (
        .clk_src (clk_src),
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .pd_req  (pd_req),
        .oe      (oe),
        .clk_out (clk_out),
        .pd_step (pd_step)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int base_h(input logic [1:0] c);
        case (c)
            2'b11:   return 1;
            2'b00:   return 2;
            2'b01:   return 4;
            default: return 8;
        endcase
    endfunction

    task automatic measure(output int hi, output int lo);
        int g;
        g  = 0;
        hi = 0;
        lo = 0;
        while (clk_out !== 1'b0 && g < 4000) begin @(negedge clk_src); g++; end
        while (clk_out !== 1'b1 && g < 4000) begin @(negedge clk_src); g++; end
        while (clk_out === 1'b1 && g < 4000) begin hi++; @(negedge clk_src); g++; end
        while (clk_out === 1'b0 && g < 4000) begin lo++; @(negedge clk_src); g++; end
    endtask

    task automatic wait_step(input int k);
        int g;
        g = 0;
        while (pd_step !== 3'(k) && g < 3000) begin @(negedge clk_ref); g++; end
        check("R4/R6 step reached", int'(pd_step), k);
    endtask

    // Status monitor: unit moves and pacing between interior changes
    int         ref_cyc  = 0;
    int         last_chg = 0;
    logic [2:0] prev_st  = 3'd0;
    always @(negedge clk_ref) begin
        if (rst_n) begin
            ref_cyc++;
            if (pd_step !== prev_st) begin
                check("R4 step moves by one",
                      (int'(pd_step) > int'(prev_st)) ? int'(pd_step) - int'(prev_st)
                                                      : int'(prev_st) - int'(pd_step), 1);
                if (prev_st != 3'd0 && prev_st != 3'(STEPS))
                    check("R5 step spacing in ref cycles", ref_cyc - last_chg, PACE);
                last_chg = ref_cyc;
                prev_st  = pd_step;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, ones;
        logic [1:0] codes [4];
        codes[0] = 2'b11; codes[1] = 2'b00; codes[2] = 2'b01; codes[3] = 2'b10;

        repeat (3) @(negedge clk_src);
        check("R9 output low in reset", int'(clk_out), 0);
        check("R9 status zero in reset", int'(pd_step), 0);
        rst_n = 1'b1;

        // R1 / R2: sweep all select codes
        for (int c = 0; c < 4; c++) begin
            sel_n = codes[c];
            repeat (300) @(negedge clk_src);
            for (int p = 0; p < 2; p++) begin
                measure(hi, lo);
                check("R1 high time", hi, base_h(codes[c]));
                check("R2 low equals high", lo, hi);
            end
        end

        // R8: select changes at arbitrary times
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    sel_n = codes[(i * 3 + i / 4) % 4];
                    repeat (5 + (i * 7) % 29) @(negedge clk_src);
                end
            end
            begin
                for (int p = 0; p < 25; p++) begin
                    measure(hi, lo);
                    check("R8 period symmetric", lo, hi);
                    check("R8 legal length", int'(hi == 1 || hi == 2 || hi == 4 || hi == 8), 1);
                end
            end
        join

        // R4 / R3: stepping down in frequency
        sel_n = 2'b11;
        repeat (100) @(negedge clk_src);
        pd_req = 1'b1;
        for (int k = 1; k <= STEPS; k++) begin
            wait_step(k);
            repeat (60) @(negedge clk_src);
            measure(hi, lo);
            check("R4 high time at step", hi, 1 << k);
            check("R4 low time at step", lo, 1 << k);
        end
        repeat (100) @(negedge clk_src);
        measure(hi, lo);
        check("R3 full power-down sel 11", hi, 16);
        sel_n = 2'b10;
        repeat (600) @(negedge clk_src);
        measure(hi, lo);
        check("R3 full power-down sel 10 high", hi, 128);
        check("R3 full power-down sel 10 low", lo, 128);
        sel_n = 2'b11;
        repeat (300) @(negedge clk_src);

        // R6: stepping back up
        pd_req = 1'b0;
        for (int k = STEPS - 1; k >= 0; k--) begin
            wait_step(k);
            repeat (60) @(negedge clk_src);
            measure(hi, lo);
            check("R6 high time on release", hi, 1 << k);
        end
        repeat (200) @(negedge clk_src);
        measure(hi, lo);
        check("R6 programmed ratio restored", hi, 1);

        // R7: enable gating at a safe point
        sel_n = 2'b01;
        repeat (100) @(negedge clk_src);
        begin
            int g;
            g = 0;
            while (clk_out !== 1'b0 && g < 200) begin @(negedge clk_src); g++; end
            while (clk_out !== 1'b1 && g < 200) begin @(negedge clk_src); g++; end
        end
        oe = 1'b0;
        hi = 0;
        while (clk_out === 1'b1 && hi < 100) begin hi++; @(negedge clk_src); end
        check("R7 started high pulse kept whole", hi, 4);
        ones = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_src);
            if (clk_out !== 1'b0) ones++;
        end
        check("R7 output held low while disabled", ones, 0);
        oe = 1'b1;
        repeat (20) @(negedge clk_src);
        measure(hi, lo);
        check("R7 resumes high time", hi, 4);
        check("R7 resumes low time", lo, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule